// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the bus interface of a 16-bit processor with a 20-bit address space. It takes one internal read or write request at a time and plays it out as a multiplexed bus cycle of four clock states. The low sixteen address bits share their pins with the data. The four top address bits share theirs with a status nibble. An address-latch strobe tells external latches when to capture the address. A direction line and a data-buffer enable steer the external transceivers. Active-low read and write strobes frame the transfer.

A slow device holds READY low to stretch a cycle with wait states. A byte or a word can be moved. The high-byte enable and address bit 0 together pick the data lanes, and read bytes are brought down to the low byte of the result. A bus master that wants the bus raises HOLD. The sequencer finishes the cycle in flight, floats its address, data and control pins, and answers with HLDA until HOLD falls.

Top module: `mxbus_biu`

## Requirements
- R1: After reset the unit is idle: ale=0, rd_n=1, wr_n=1, buf_en=0, ad_oe=0, hlda=0, ctl_oe=1.
- R2: req_accept is high in the cycle a request is taken. The next cycle is T1, in which ale=1 for exactly that one cycle, ad_oe=1, ad_out=addr[15:0], ahs_out=addr[19:16], m_io=1 for memory and 0 for I/O, and dt_r=1 for a write and 0 for a read.
- R3: In T2, in every wait state and in T3, exactly one strobe is low (rd_n for a read, wr_n for a write) and buf_en=1. ahs_out carries status as {bit3=0, bit2=interrupt-enable flag, bits1:0=segment code}.
- R4: For a write, ad_oe=1 and ad_out holds the write data from T2 through T3. For a read, ad_oe=0 from T2 through T4.
- R5: READY is sampled at the end of T2 and of each wait state. Each low sample adds one wait state with the strobe held low, and a high sample moves to T3.
- R6: Read data on ad_in is captured at the end of T3. done=1 in T4, and rdata holds the captured value.
- R7: In T4 both strobes are high, buf_en=0 and ad_oe=0.
- R8: Lane select: a word at an even address gives bhe_n=0 and A0=0. A byte at an even address gives bhe_n=1. A byte at an odd address gives bhe_n=0 and A0=1. A word at an odd address is handled as an odd byte.
- R9: Byte writes drive the byte on both lanes ({b,b}). Byte reads return {8'h00, upper lane} at an odd address and {8'h00, lower lane} at an even address. Word reads return the full bus.
- R10: HOLD raised during a cycle lets that cycle run through T4. HOLD raised while idle takes effect at the next clock. While hlda=1, ad_oe, ahs_oe and ctl_oe are 0 and no request is accepted. When HOLD falls the unit returns to idle.
- R11: A request waiting in T4 is accepted there, and its T1 follows directly, with no idle cycle between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| req_seg | input | 2 | Segment code for status |
| req_ie | input | 1 | Interrupt-enable flag for status |
| req_accept | output | 1 | Request taken this cycle |
| done | output | 1 | Cycle in its final state |
| rdata | output | 16 | Read result |
| ad_out | output | 16 | Shared address/data lines, driven value |
| ad_oe | output | 1 | Drive enable for ad_out |
| ad_in | input | 16 | Shared address/data lines, sampled value |
| ahs_out | output | 4 | Upper address, then status |
| ahs_oe | output | 1 | Drive enable for ahs_out |
| ale | output | 1 | Address latch strobe |
| m_io | output | 1 | Memory/I-O select |
| dt_r | output | 1 | Transceiver direction, 1 = transmit |
| buf_en | output | 1 | Data buffer enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bhe_n | output | 1 | High byte lane enable, active low |
| ctl_oe | output | 1 | Drive enable for control outputs |
| ready | input | 1 | Device ready, low inserts waits |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus granted to the other master |

## Verification
A table runs word and byte transfers at even and odd addresses, in both directions and in both address spaces, with zero to three wait states. This separates lane and bhe_n errors from mistakes in direction, status or wait counting. Because the data on ad_in is changed only in T3, capture in the wrong state shows up as a wrong result. Back-to-back requests check that a request is taken in T4. Directed runs raise HOLD while idle and in the middle of a cycle, which tells an immediate grant apart from a grant that waits for the cycle to end.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int STAT_W = ADDR_W - DATA_W;
    localparam int BYTE_W = DATA_W / 2;
    localparam int SEG_W  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_TW,
        ST_T3,
        ST_T4,
        ST_HELD
    } bstate_e;

    typedef struct packed {
        logic              write;
        logic              mem;
        logic              word;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [SEG_W-1:0]  seg;
        logic              ie;
    } breq_t;

    // word only uses both lanes when aligned
    function automatic logic both_lanes(input breq_t r);
        return r.word && !r.addr[0];
    endfunction

    function automatic logic high_lane_n(input breq_t r);
        return !(r.addr[0] || r.word);
    endfunction

    function automatic logic [STAT_W-1:0] status_nib(input breq_t r);
        return {{(STAT_W-SEG_W-1){1'b0}}, r.ie, r.seg};
    endfunction

    function automatic logic [DATA_W-1:0] wlane(input breq_t r);
        if (both_lanes(r))
            return r.wdata;
        return {r.wdata[BYTE_W-1:0], r.wdata[BYTE_W-1:0]};
    endfunction

    function automatic logic [DATA_W-1:0] rlane(input breq_t r, input logic [DATA_W-1:0] bus);
        if (r.addr[0])
            return {{BYTE_W{1'b0}}, bus[DATA_W-1:BYTE_W]};
        if (r.word)
            return bus;
        return {{BYTE_W{1'b0}}, bus[BYTE_W-1:0]};
    endfunction

endpackage

// File: rtl/mxb_fsm.sv
module mxb_fsm
    import mxb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  logic    ready,
    input  logic    hold,
    output bstate_e state,
    output logic    accept
);

    bstate_e nxt;
    logic    at_boundary;

    assign at_boundary = (state == ST_IDLE) || (state == ST_T4);
    assign accept      = at_boundary && !hold && req_valid;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE, ST_T4: begin
                if (hold)
                    nxt = ST_HELD;
                else if (req_valid)
                    nxt = ST_T1;
                else
                    nxt = ST_IDLE;
            end
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = ready ? ST_T3 : ST_TW;
            ST_TW:   nxt = ready ? ST_T3 : ST_TW;
            ST_T3:   nxt = ST_T4;
            ST_HELD: nxt = hold ? ST_HELD : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

endmodule

// File: rtl/mxb_ctl.sv
module mxb_ctl
    import mxb_pkg::*;
(
    input  bstate_e state,
    input  breq_t   cur,
    output logic    ale,
    output logic    rd_n,
    output logic    wr_n,
    output logic    buf_en,
    output logic    m_io,
    output logic    dt_r,
    output logic    bhe_n,
    output logic    ctl_oe,
    output logic    hlda,
    output logic    done
);

    logic xfer;

    assign xfer   = (state == ST_T2) || (state == ST_TW) || (state == ST_T3);
    assign ale    = (state == ST_T1);
    assign rd_n   = !(xfer && !cur.write);
    assign wr_n   = !(xfer && cur.write);
    assign buf_en = xfer;
    assign m_io   = cur.mem;
    assign dt_r   = cur.write;
    assign bhe_n  = high_lane_n(cur);
    assign hlda   = (state == ST_HELD);
    assign ctl_oe = !hlda;
    assign done   = (state == ST_T4);

endmodule

// File: rtl/mxb_dpath.sv
module mxb_dpath
    import mxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  breq_t             req,
    input  bstate_e           state,
    input  logic [DATA_W-1:0] ad_in,
    output breq_t             cur,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [STAT_W-1:0] ahs_out,
    output logic              ahs_oe,
    output logic [DATA_W-1:0] rdata
);

    logic data_phase;

    assign data_phase = (state == ST_T2) || (state == ST_TW) || (state == ST_T3);

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;
        else if (accept)
            cur <= req;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (state == ST_T3 && !cur.write)
            rdata <= rlane(cur, ad_in);
    end

    assign ad_out  = (state == ST_T1) ? cur.addr[DATA_W-1:0] : wlane(cur);
    assign ad_oe   = (state == ST_T1) || (data_phase && cur.write);
    assign ahs_out = (state == ST_T1) ? cur.addr[ADDR_W-1:DATA_W] : status_nib(cur);
    assign ahs_oe  = (state == ST_T1) || data_phase || (state == ST_T4);

endmodule

// File: rtl/mxbus_biu.sv
module mxbus_biu
    import mxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_mem,
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic              req_ie,
    output logic              req_accept,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic [STAT_W-1:0] ahs_out,
    output logic              ahs_oe,
    output logic              ale,
    output logic              m_io,
    output logic              dt_r,
    output logic              buf_en,
    output logic              rd_n,
    output logic              wr_n,
    output logic              bhe_n,
    output logic              ctl_oe,
    input  logic              ready,
    input  logic              hold,
    output logic              hlda
);

    bstate_e state;
    breq_t   req;
    breq_t   cur;

    assign req = '{write: req_write, mem: req_mem, word: req_word, addr: req_addr,
                   wdata: req_wdata, seg: req_seg, ie: req_ie};

    mxb_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .ready     (ready),
        .hold      (hold),
        .state     (state),
        .accept    (req_accept)
    );

    mxb_dpath u_dpath (
        .clk     (clk),
        .rst     (rst),
        .accept  (req_accept),
        .req     (req),
        .state   (state),
        .ad_in   (ad_in),
        .cur     (cur),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .ahs_out (ahs_out),
        .ahs_oe  (ahs_oe),
        .rdata   (rdata)
    );

    mxb_ctl u_ctl (
        .state  (state),
        .cur    (cur),
        .ale    (ale),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .buf_en (buf_en),
        .m_io   (m_io),
        .dt_r   (dt_r),
        .bhe_n  (bhe_n),
        .ctl_oe (ctl_oe),
        .hlda   (hlda),
        .done   (done)
    );

endmodule

// File: rtl/mxb_chk.sv
module mxb_chk (
    input logic clk,
    input logic rst,
    input logic ale,
    input logic ad_oe,
    input logic ahs_oe,
    input logic ctl_oe,
    input logic rd_n,
    input logic wr_n,
    input logic buf_en,
    input logic ready,
    input logic hlda,
    input logic done
);

    // R2
    ale_pulse_chk: assert property (@(posedge clk) disable iff (rst) ale |=> !ale);

    // R2
    ale_addr_chk: assert property (@(posedge clk) disable iff (rst) ale |-> (ad_oe && ahs_oe));

    // R4
    rd_float_chk: assert property (@(posedge clk) disable iff (rst) !rd_n |-> !ad_oe);

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst) (rd_n || wr_n));

    // R5
    wait_extend_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ale) && !ready) |=> ##1 buf_en);

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (rd_n && wr_n && !buf_en && !ad_oe));

    // R10
    hold_float_chk: assert property (@(posedge clk) disable iff (rst)
        hlda |-> (!ad_oe && !ahs_oe && !ctl_oe));

endmodule

bind mxbus_biu mxb_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .ale    (ale),
    .ad_oe  (ad_oe),
    .ahs_oe (ahs_oe),
    .ctl_oe (ctl_oe),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .buf_en (buf_en),
    .ready  (ready),
    .hlda   (hlda),
    .done   (done)
);

// File: tb/sim_mxbus_biu.sv
module sim_mxbus_biu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0, req_word = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_seg = '0;
    logic        req_ie = 1'b0;
    logic        req_accept, done;
    logic [15:0] rdata, ad_out;
    logic        ad_oe;
    logic [15:0] ad_in = 16'h5A5A;
    logic [3:0]  ahs_out;
    logic        ahs_oe, ale, m_io, dt_r, buf_en, rd_n, wr_n, bhe_n, ctl_oe, hlda;
    logic        ready = 1'b1;
    logic        hold = 1'b0;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    mxbus_biu u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_mem(req_mem), .req_word(req_word), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_seg(req_seg), .req_ie(req_ie),
        .req_accept(req_accept), .done(done), .rdata(rdata), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .ahs_out(ahs_out), .ahs_oe(ahs_oe),
        .ale(ale), .m_io(m_io), .dt_r(dt_r), .buf_en(buf_en), .rd_n(rd_n),
        .wr_n(wr_n), .bhe_n(bhe_n), .ctl_oe(ctl_oe), .ready(ready),
        .hold(hold), .hlda(hlda)
    );

    typedef struct packed {
        logic        wr;
        logic        mem;
        logic        word;
        logic [19:0] addr;
        logic [15:0] wdata;
        logic [1:0]  seg;
        logic        ie;
        logic [1:0]  waits;
        logic [15:0] rdin;
        logic        exp_bhe_n;
        logic [15:0] exp_data;
    } vec_t;

    // exp_data: bus data for writes (R9 replication), rdata for reads (R9 steering)
    localparam vec_t VECS [8] = '{
        '{1'b1, 1'b1, 1'b1, 20'h12344, 16'hBEEF, 2'b11, 1'b1, 2'd0, 16'h0000, 1'b0, 16'hBEEF},
        '{1'b0, 1'b1, 1'b1, 20'hA5670, 16'h0000, 2'b10, 1'b0, 2'd2, 16'h1357, 1'b0, 16'h1357},
        '{1'b1, 1'b0, 1'b0, 20'h00102, 16'h00AB, 2'b01, 1'b1, 2'd0, 16'h0000, 1'b1, 16'hABAB},
        '{1'b1, 1'b1, 1'b0, 20'hF0031, 16'h0077, 2'b00, 1'b0, 2'd1, 16'h0000, 1'b0, 16'h7777},
        '{1'b0, 1'b1, 1'b0, 20'h00035, 16'h0000, 2'b11, 1'b1, 2'd0, 16'hC3D4, 1'b0, 16'h00C3},
        '{1'b0, 1'b1, 1'b0, 20'h4FFF8, 16'h0000, 2'b10, 1'b0, 2'd1, 16'hC3D4, 1'b1, 16'h00D4},
        '{1'b0, 1'b0, 1'b1, 20'h00060, 16'h0000, 2'b00, 1'b1, 2'd0, 16'h8001, 1'b0, 16'h8001},
        '{1'b1, 1'b0, 1'b1, 20'hFFFFE, 16'h0F0F, 2'b01, 1'b1, 2'd3, 16'h0000, 1'b0, 16'h0F0F}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic strobe_chk(input vec_t v, input string tag);
        chk(rd_n == v.wr, {tag, " rd_n"}, rd_n, v.wr);
        chk(wr_n == !v.wr, {tag, " wr_n"}, wr_n, !v.wr);
        chk(buf_en == 1'b1, {tag, " buf_en"}, buf_en, 1);
    endtask

    // called at a negedge; returns at the negedge inside T4
    task automatic run_vec(input vec_t v, input bit back2back);
        req_valid = 1'b1; req_write = v.wr; req_mem = v.mem; req_word = v.word;
        req_addr = v.addr; req_wdata = v.wdata; req_seg = v.seg; req_ie = v.ie;
        #1;
        chk(req_accept == 1'b1, back2back ? "R11 accept in T4" : "R2 accept", req_accept, 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(ale == 1'b1, "R2 ale in T1", ale, 1);
        chk(ad_oe && ad_out == v.addr[15:0], "R2 address low", {ad_oe, ad_out}, {1'b1, v.addr[15:0]});
        chk(ahs_out == v.addr[19:16], "R2 address high", ahs_out, v.addr[19:16]);
        chk(m_io == v.mem && dt_r == v.wr, "R2 m_io/dt_r", {m_io, dt_r}, {v.mem, v.wr});
        chk(bhe_n == v.exp_bhe_n && ad_out[0] == v.addr[0], "R8 lanes", {bhe_n, ad_out[0]},
            {v.exp_bhe_n, v.addr[0]});
        @(negedge clk);
        chk(ale == 1'b0, "R2 ale single", ale, 0);
        strobe_chk(v, "R3 T2");
        chk(ahs_out == {1'b0, v.ie, v.seg}, "R3 status", ahs_out, {1'b0, v.ie, v.seg});
        chk(ad_oe == v.wr, "R4 ad_oe T2", ad_oe, v.wr);
        if (v.wr) chk(ad_out == v.exp_data, "R9 write lanes", ad_out, v.exp_data);
        ready = (v.waits == 0);
        for (int w = 0; w < int'(v.waits); w++) begin
            @(negedge clk);
            strobe_chk(v, "R5 wait");
            chk(done == 1'b0, "R5 no early end", done, 0);
            ready = (w == int'(v.waits) - 1);
        end
        @(negedge clk);
        strobe_chk(v, "R3 T3");
        chk(ad_oe == v.wr, "R4 ad_oe T3", ad_oe, v.wr);
        ad_in = v.rdin;
        ready = 1'b1;
        @(negedge clk);
        ad_in = 16'h5A5A;
        chk(done == 1'b1, "R6 done T4", done, 1);
        chk(rd_n && wr_n && !buf_en && !ad_oe, "R7 T4 quiet",
            {rd_n, wr_n, buf_en, ad_oe}, 4'b1100);
        if (!v.wr) chk(rdata == v.exp_data, "R6 R9 read data", rdata, v.exp_data);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(!ale && rd_n && wr_n && !buf_en && !ad_oe && !hlda && ctl_oe, "R1 reset state",
            {ale, rd_n, wr_n, buf_en, ad_oe, hlda, ctl_oe}, 7'b0110001);

        for (int i = 0; i < 8; i++) run_vec(VECS[i], i != 0);

        // R10 hold while idle
        @(negedge clk);
        hold = 1'b1;
        #1 chk(hlda == 1'b0, "R10 hlda before edge", hlda, 0);
        @(negedge clk);
        chk(hlda == 1'b1, "R10 hlda idle", hlda, 1);
        chk(!ad_oe && !ahs_oe && !ctl_oe, "R10 floated", {ad_oe, ahs_oe, ctl_oe}, 0);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h00200; req_word = 1'b1;
        #1 chk(req_accept == 1'b0, "R10 no accept in hold", req_accept, 0);
        req_valid = 1'b0;
        hold = 1'b0;
        @(negedge clk);
        chk(hlda == 1'b0 && ctl_oe == 1'b1 && ale == 1'b0, "R10 release idle",
            {hlda, ctl_oe, ale}, 3'b010);

        // R10 hold in mid cycle
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        hold = 1'b1;
        @(negedge clk);
        chk(hlda == 1'b0 && rd_n == 1'b0, "R10 T2 continues", {hlda, rd_n}, 2'b00);
        @(negedge clk);
        chk(hlda == 1'b0 && rd_n == 1'b0, "R10 T3 continues", {hlda, rd_n}, 2'b00);
        @(negedge clk);
        chk(done == 1'b1 && hlda == 1'b0, "R10 T4 completes", {done, hlda}, 2'b10);
        @(negedge clk);
        chk(hlda == 1'b1 && !ad_oe && !ctl_oe, "R10 grant after cycle",
            {hlda, ad_oe, ctl_oe}, 3'b100);
        hold = 1'b0;
        @(negedge clk);
        chk(hlda == 1'b0, "R10 hold released", hlda, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule